// File: doc/BRIEF.md
# Conditional Execute and Branch-Target Unit

This block sits beside an instruction decoder and answers two questions for every 32-bit instruction word presented to it. The first is whether the instruction may execute at all: the top four bits of every instruction carry a condition code, and the block tests that code against the current negative, zero, carry and overflow flags. The second question applies only to branches. For a branch, the block forms the target address from a signed word offset held in the low 24 bits. That offset is added to a program counter that is two words ahead of the branch.

The execute and taken decisions are combinational, so they are ready in the cycle the instruction is presented. The branch target is registered once and marked by a one-cycle valid strobe. For a branch-and-link, the block also registers a request to write the return address (instruction address plus 4) into the link register. Fetch, the flag-producing ALU and the register file belong to the surrounding pipeline.

Top module: `cond_branch_unit`

## Requirements
- R1: Condition code 4'b1111 in bits 31:28 never executes: `exec_en` and `br_taken` are 0 whatever the flags.
- R2: Condition code 4'b1110 always executes: with `instr_valid` high, `exec_en` is 1 whatever the flags.
- R3: The other codes in bits 31:28 are tested against the flags. 0000 needs Z=1 and 0001 needs Z=0. 0010 needs C=1 and 0011 needs C=0. 0100 needs N=1 and 0101 needs N=0. 0110 needs V=1 and 0111 needs V=0. 1000 needs C=1 and Z=0, and 1001 needs C=0 or Z=1. 1010 needs N==V and 1011 needs N!=V. 1100 needs Z=0 and N==V, and 1101 needs Z=1 or N!=V.
- R4: `exec_en` is combinational and equals `instr_valid` AND the condition result, in the same cycle. With `instr_valid` low, `exec_en` and `br_taken` are 0.
- R5: An instruction is a branch when bits 27:25 equal 3'b101. `br_taken` equals `exec_en` AND that decode, combinationally.
- R6: The target equals the instruction address + 8 + (bits 23:0, sign-extended and multiplied by 4), modulo 2^32. For example, a branch at 1000 with offset field 23 targets 1100.
- R7: One clock edge after a cycle with `br_taken` high, `tgt_valid` is 1 for one cycle and `tgt_addr` holds the target. `tgt_addr` keeps its value until the next taken branch.
- R8: A taken branch with bit 24 = 1 raises `link_we` together with `tgt_valid`, and `link_addr` then holds the instruction address + 4. A taken branch with bit 24 = 0 leaves `link_we` at 0.
- R9: While `rst_n` is low, `tgt_valid` and `link_we` are 0 and `tgt_addr` and `link_addr` are zero.
- R10: Both condition-evaluator variants (`EVAL_STYLE` 0 and 1) give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| instr_addr | input | ADDR_W | Address of the presented instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| exec_en | output | 1 | Instruction may execute (combinational) |
| br_taken | output | 1 | Branch taken (combinational) |
| tgt_valid | output | 1 | Registered target is new this cycle |
| tgt_addr | output | ADDR_W | Registered branch target |
| link_we | output | 1 | Link register write request |
| link_addr | output | ADDR_W | Return address to write |

## Verification
The bench builds two copies at the default 32-bit address width, 24-bit offset, shift of 2 and look-ahead of 8. One uses the paired evaluator (`EVAL_STYLE`=1) and the other the case-table evaluator (`EVAL_STYLE`=0), and the bench compares them on every vector. The default widths make the extreme offsets reachable: the most negative and most positive 24-bit fields exercise sign extension and 32-bit address wrap. Random flags, applied across all sixteen codes, cover every row of the condition table.

// File: rtl/cbu_pkg.sv
`timescale 1ns/1ps
package cbu_pkg;
   typedef enum logic [3:0] {
      CND_EQ = 4'h0, CND_NE = 4'h1, CND_CS = 4'h2, CND_CC = 4'h3,
      CND_MI = 4'h4, CND_PL = 4'h5, CND_VS = 4'h6, CND_VC = 4'h7,
      CND_HI = 4'h8, CND_LS = 4'h9, CND_GE = 4'hA, CND_LT = 4'hB,
      CND_GT = 4'hC, CND_LE = 4'hD, CND_AL = 4'hE, CND_NV = 4'hF
   } cond_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   localparam int INSTR_W   = 32;
   localparam int COND_MSB  = 31;
   localparam int COND_LSB  = 28;
   localparam logic [2:0] BR_GROUP = 3'b101;
   localparam int LINK_BIT  = 24;
endpackage

// File: rtl/cbu_cond_eval.sv
`timescale 1ns/1ps
module cbu_cond_eval
   import cbu_pkg::*;
#(
   parameter int EVAL_STYLE = 1
) (
   input  logic [3:0] code,
   input  flags_t     flags,
   output logic       pass
);
   initial begin
      if (EVAL_STYLE != 0 && EVAL_STYLE != 1)
         $error("cbu_cond_eval: EVAL_STYLE must be 0 or 1");
   end

   generate
      if (EVAL_STYLE == 1) begin : g_paired
         // even code = base test, odd code = its inverse
         logic base;
         always_comb begin
            unique case (code[3:1])
               3'd0:    base = flags.z;
               3'd1:    base = flags.c;
               3'd2:    base = flags.n;
               3'd3:    base = flags.v;
               3'd4:    base = flags.c & ~flags.z;
               3'd5:    base = ~(flags.n ^ flags.v);
               3'd6:    base = ~flags.z & ~(flags.n ^ flags.v);
               default: base = 1'b1;
            endcase
         end
         assign pass = base ^ code[0];
      end else begin : g_table
         logic res;
         always_comb begin
            unique case (cond_e'(code))
               CND_EQ:  res = flags.z;
               CND_NE:  res = ~flags.z;
               CND_CS:  res = flags.c;
               CND_CC:  res = ~flags.c;
               CND_MI:  res = flags.n;
               CND_PL:  res = ~flags.n;
               CND_VS:  res = flags.v;
               CND_VC:  res = ~flags.v;
               CND_HI:  res = flags.c & ~flags.z;
               CND_LS:  res = ~flags.c | flags.z;
               CND_GE:  res = (flags.n == flags.v);
               CND_LT:  res = (flags.n != flags.v);
               CND_GT:  res = ~flags.z & (flags.n == flags.v);
               CND_LE:  res = flags.z | (flags.n != flags.v);
               CND_AL:  res = 1'b1;
               default: res = 1'b0;
            endcase
         end
         assign pass = res;
      end
   endgenerate
endmodule

// File: rtl/cbu_target_calc.sv
`timescale 1ns/1ps
module cbu_target_calc #(
   parameter int ADDR_W    = 32,
   parameter int OFS_W     = 24,
   parameter int SCALE     = 2,
   parameter int PC_AHEAD  = 8,
   parameter int LINK_STEP = 4
) (
   input  logic [OFS_W-1:0]  ofs_field,
   input  logic [ADDR_W-1:0] base_addr,
   output logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] ret_addr
);
   localparam int EXT_W = ADDR_W - OFS_W - SCALE;

   initial begin
      if (EXT_W < 1)
         $error("cbu_target_calc: ADDR_W too small for OFS_W and SCALE");
      if (PC_AHEAD < 0 || LINK_STEP < 0)
         $error("cbu_target_calc: negative address step");
   end

   logic [ADDR_W-1:0] disp;
   logic [ADDR_W-1:0] ahead;

   generate
      if (SCALE > 0) begin : g_scaled
         assign disp = {{EXT_W{ofs_field[OFS_W-1]}}, ofs_field, {SCALE{1'b0}}};
      end else begin : g_unscaled
         assign disp = {{EXT_W{ofs_field[OFS_W-1]}}, ofs_field};
      end
   endgenerate

   assign ahead    = base_addr + ADDR_W'(PC_AHEAD);
   assign target   = ahead + disp;
   assign ret_addr = base_addr + ADDR_W'(LINK_STEP);
endmodule

// File: rtl/cbu_result_reg.sv
`timescale 1ns/1ps
module cbu_result_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              link_req,
   input  logic [ADDR_W-1:0] tgt_in,
   input  logic [ADDR_W-1:0] link_in,
   output logic              tgt_valid,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic              link_we,
   output logic [ADDR_W-1:0] link_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_valid <= 1'b0;
         link_we   <= 1'b0;
         tgt_addr  <= '0;
         link_addr <= '0;
      end else begin
         tgt_valid <= load;
         link_we   <= load & link_req;
         if (load) begin
            tgt_addr <= tgt_in;
         end
         if (load && link_req) begin
            link_addr <= link_in;
         end
      end
   end
endmodule

// File: rtl/cond_branch_unit.sv
`timescale 1ns/1ps
module cond_branch_unit
   import cbu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int OFS_W      = 24,
   parameter int SCALE      = 2,
   parameter int PC_AHEAD   = 8,
   parameter int LINK_STEP  = 4,
   parameter int EVAL_STYLE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr,
   input  logic [ADDR_W-1:0] instr_addr,
   input  logic              flag_n,
   input  logic              flag_z,
   input  logic              flag_c,
   input  logic              flag_v,
   output logic              exec_en,
   output logic              br_taken,
   output logic              tgt_valid,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic              link_we,
   output logic [ADDR_W-1:0] link_addr
);
   initial begin
      if (OFS_W > LINK_BIT)
         $error("cond_branch_unit: offset field overlaps link bit");
   end

   flags_t            flags;
   logic              cond_ok;
   logic              is_branch;
   logic [ADDR_W-1:0] tgt_comb;
   logic [ADDR_W-1:0] ret_comb;

   assign flags     = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};
   assign is_branch = (instr[27:25] == BR_GROUP);

   cbu_cond_eval #(.EVAL_STYLE(EVAL_STYLE)) u_cond (
      .code  (instr[COND_MSB:COND_LSB]),
      .flags (flags),
      .pass  (cond_ok)
   );

   cbu_target_calc #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SCALE(SCALE),
      .PC_AHEAD(PC_AHEAD), .LINK_STEP(LINK_STEP)
   ) u_calc (
      .ofs_field (instr[OFS_W-1:0]),
      .base_addr (instr_addr),
      .target    (tgt_comb),
      .ret_addr  (ret_comb)
   );

   assign exec_en  = instr_valid & cond_ok;
   assign br_taken = exec_en & is_branch;

   cbu_result_reg #(.ADDR_W(ADDR_W)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (br_taken),
      .link_req  (instr[LINK_BIT]),
      .tgt_in    (tgt_comb),
      .link_in   (ret_comb),
      .tgt_valid (tgt_valid),
      .tgt_addr  (tgt_addr),
      .link_we   (link_we),
      .link_addr (link_addr)
   );
endmodule

// File: rtl/cbu_checker.sv
`timescale 1ns/1ps
module cbu_checker #(
   parameter int ADDR_W    = 32,
   parameter int LINK_STEP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic [31:0]       instr,
   input logic [ADDR_W-1:0] instr_addr,
   input logic              flag_z,
   input logic              exec_en,
   input logic              br_taken,
   input logic              tgt_valid,
   input logic              link_we,
   input logic [ADDR_W-1:0] link_addr
);
   a_r1_never_code: assert property (@(posedge clk) disable iff (!rst_n)
      (instr[31:28] == 4'hF) |-> !exec_en && !br_taken);

   a_r2_always_code: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr[31:28] == 4'hE) |-> exec_en);

   a_r3_equal_code: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr[31:28] == 4'h0) |-> (exec_en == flag_z));

   a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> !exec_en && !br_taken);

   a_r5_taken_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |-> exec_en && instr[27:25] == 3'b101);

   a_r7_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |=> tgt_valid);

   a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !br_taken |=> !tgt_valid);

   a_r8_link_value: assert property (@(posedge clk) disable iff (!rst_n)
      (br_taken && instr[24]) |=>
         link_we && link_addr == ADDR_W'($past(instr_addr) + ADDR_W'(LINK_STEP)));

   a_r8_no_link: assert property (@(posedge clk) disable iff (!rst_n)
      (br_taken && !instr[24]) |=> !link_we);
endmodule

bind cond_branch_unit cbu_checker #(.ADDR_W(ADDR_W), .LINK_STEP(LINK_STEP)) u_chk (
   .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
   .instr_addr(instr_addr), .flag_z(flag_z), .exec_en(exec_en),
   .br_taken(br_taken), .tgt_valid(tgt_valid), .link_we(link_we),
   .link_addr(link_addr)
);

// File: tb/cond_branch_unit_test.sv
`timescale 1ns/1ps
module cond_branch_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] instr_addr = '0;
   logic        fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;

   logic        exec_en, br_taken, tgt_valid, link_we;
   logic [31:0] tgt_addr, link_addr;
   logic        exec_en2, br_taken2, tgt_valid2, link_we2;
   logic [31:0] tgt_addr2, link_addr2;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] held_tgt = '0;
   logic [31:0] held_link = '0;

   always #5 clk = ~clk;

   cond_branch_unit #(.EVAL_STYLE(1)) uut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .instr_addr(instr_addr), .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
      .exec_en(exec_en), .br_taken(br_taken), .tgt_valid(tgt_valid),
      .tgt_addr(tgt_addr), .link_we(link_we), .link_addr(link_addr));

   cond_branch_unit #(.EVAL_STYLE(0)) uut_case (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .instr_addr(instr_addr), .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
      .exec_en(exec_en2), .br_taken(br_taken2), .tgt_valid(tgt_valid2),
      .tgt_addr(tgt_addr2), .link_we(link_we2), .link_addr(link_addr2));

   function automatic logic exp_cond(input logic [3:0] code,
                                     input logic n, z, c, v);
      case (code)
         4'h0: return z;          4'h1: return !z;
         4'h2: return c;          4'h3: return !c;
         4'h4: return n;          4'h5: return !n;
         4'h6: return v;          4'h7: return !v;
         4'h8: return c && !z;    4'h9: return !c || z;
         4'hA: return n == v;     4'hB: return n != v;
         4'hC: return !z && n == v;
         4'hD: return z || n != v;
         4'hE: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] exp_target(input logic [31:0] a,
                                              input logic [23:0] f);
      logic [31:0] d;
      d = {{6{f[23]}}, f, 2'b00};
      return a + 32'd8 + d;
   endfunction

   task automatic check(input logic ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic v, input logic [31:0] ins,
                        input logic [31:0] addr, input logic [3:0] f);
      logic e_ex, e_tk;
      @(negedge clk);
      instr_valid = v; instr = ins; instr_addr = addr;
      {fn, fz, fc, fv} = f;
      #1;
      e_ex = v && exp_cond(ins[31:28], f[3], f[2], f[1], f[0]);
      e_tk = e_ex && ins[27:25] == 3'b101;
      // R1 R2 R3 R4: execute decision
      check(exec_en == e_ex, "R3/R4 exec_en", 32'(exec_en), 32'(e_ex));
      // R5: taken decision
      check(br_taken == e_tk, "R5 br_taken", 32'(br_taken), 32'(e_tk));
      // R10: variants agree
      check(exec_en2 == exec_en && br_taken2 == br_taken, "R10 comb agree",
            32'({exec_en2, br_taken2}), 32'({exec_en, br_taken}));
      @(posedge clk); #1;
      if (e_tk) begin
         held_tgt = exp_target(addr, ins[23:0]);
         if (ins[24]) held_link = addr + 32'd4;
      end
      // R7: strobe and target held or updated (R6 value)
      check(tgt_valid == e_tk, "R7 tgt_valid", 32'(tgt_valid), 32'(e_tk));
      check(tgt_addr == held_tgt, "R6 tgt_addr", tgt_addr, held_tgt);
      // R8: link request and return value
      check(link_we == (e_tk && ins[24]), "R8 link_we", 32'(link_we),
            32'(e_tk && ins[24]));
      check(link_addr == held_link, "R8 link_addr", link_addr, held_link);
      check(tgt_addr2 == tgt_addr && link_we2 == link_we &&
            tgt_valid2 == tgt_valid && link_addr2 == link_addr,
            "R10 reg agree", tgt_addr2, tgt_addr);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      #1;
      // R9: reset state
      check(!tgt_valid && !link_we && tgt_addr == 0 && link_addr == 0,
            "R9 reset", tgt_addr, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // R6: 1000 + 8 + 23*4 = 1100
      apply(1'b1, {4'hE, 3'b101, 1'b0, 24'd23}, 32'd1000, 4'h0);
      check(tgt_addr == 32'd1100, "R6 directed 1100", tgt_addr, 32'd1100);
      // R6: offset -1 -> addr + 4
      apply(1'b1, {4'hE, 3'b101, 1'b0, 24'hFFFFFF}, 32'h40, 4'hF);
      // R6: extreme offsets with wrap
      apply(1'b1, {4'hE, 3'b101, 1'b0, 24'h800000}, 32'h0000_0010, 4'h0);
      apply(1'b1, {4'hE, 3'b101, 1'b0, 24'h7FFFFF}, 32'hFFFF_FFF0, 4'h0);
      // R8: branch with link
      apply(1'b1, {4'hE, 3'b101, 1'b1, 24'd5}, 32'h2000, 4'h0);
      check(link_addr == 32'h2004, "R8 directed link", link_addr, 32'h2004);
      // R1: never code on a branch, all flag patterns
      for (int f = 0; f < 16; f++)
         apply(1'b1, {4'hF, 3'b101, 1'b1, 24'd9}, 32'h3000, 4'(f));
      // R2: always code, all flag patterns
      for (int f = 0; f < 16; f++)
         apply(1'b1, {4'hE, 3'b000, 1'b0, 24'd1}, 32'h3100, 4'(f));
      // R4: invalid slot leaves everything quiet, target held
      apply(1'b0, {4'hE, 3'b101, 1'b1, 24'd7}, 32'h5000, 4'h0);
      // R3: exhaustive code x flags
      for (int c = 0; c < 16; c++)
         for (int f = 0; f < 16; f++)
            apply(1'b1, {4'(c), 3'b101, 1'(f & 1), 24'(c * 16 + f)},
                  32'(c * 256), 4'(f));
      // random mix
      for (int i = 0; i < 2500; i++) begin
         logic [31:0] w;
         w = $urandom;
         if ($urandom_range(1, 0) == 1) w[27:25] = 3'b101;
         apply($urandom_range(7, 0) != 0, w, $urandom & 32'hFFFF_FFFC,
               4'($urandom));
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule